// File: doc/BRIEF.md
# Supply Interruption Pattern Generator

This block drives the enables of two high-side supply switches that feed a unit under test. The primary supply (rail A) is normally on. The secondary supply (rail B) is the alternate or spike source. A 3-bit test number selects one of five preset patterns. Each preset combines a period, a pulse width and a switching rule. The rule says whether rail A is cut, whether rail B replaces it during the cut, or whether rail B adds a short spike on top of rail A.

All timing comes from a one-microsecond tick. The pattern is captured when the enable input rises, and it repeats until the enable is removed. In the optional burst mode, the block stops by itself after exactly ten pulses and raises a done flag. The parameter `TIME_DIV` divides every preset duration, so a scaled-down copy can be built.

Top module: `supply_dip_gen`

## Requirements
- R1: After reset, and whenever no pattern runs, `rail_a_en`=1, `rail_b_en`=0 and `pulse_on`=0. `burst_done` is 0 after reset.
- R2: While idle, `enable` with `test_sel` equal to 0, 6 or 7 starts nothing, and the outputs keep their R1 values.
- R3: A pattern starts in the clock cycle after `enable` is sampled high with a valid number. The position counter starts at 0 and advances on each clock with `tick_us`=1. The pulse is inactive at position 0 and covers the last W positions of each period P, with positions running 0..P-1. `pulse_on` marks that window.
- R4: Test 1 uses P=100000/TIME_DIV and W=10000/TIME_DIV. It is a cut: rail A is off in the window, and rail B stays off.
- R5: Test 2 uses P=200000/TIME_DIV and W=20000/TIME_DIV. It is a swap: rail A is off in the window, and rail B is on there.
- R6: Test 3 uses P=5000000/TIME_DIV and W=500000/TIME_DIV. It is a swap.
- R7: Test 4 uses P=20000/TIME_DIV and W=1800/TIME_DIV. It is a cut.
- R8: Test 5 uses P=10000/TIME_DIV and W=280/TIME_DIV. It is a spike: rail A stays on, and rail B is on for the whole window.
- R9: In swap tests, rail B is off at the first and last position of the window, so the two rails are never on together.
- R10: The pattern repeats without end while `enable` stays high. The clock after `enable` is sampled low, the outputs are at their R1 values and `burst_done`=0.
- R11: With `burst_en` high at the start, the run ends as the tenth period wraps. From then on the outputs are idle and `burst_done`=1, and this holds while `enable` stays high. No restart happens until `enable` goes low.
- R12: Changes on `test_sel` or `burst_en` during a run have no effect on the running pattern.
- R13: With `tick_us`=0, the position counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| enable | input | 1 | Run request; low returns to idle |
| test_sel | input | 3 | Preset number, 1 to 5 |
| burst_en | input | 1 | Stop after ten pulses |
| rail_a_en | output | 1 | Primary supply switch enable |
| rail_b_en | output | 1 | Secondary supply switch enable |
| pulse_on | output | 1 | Pulse window active |
| burst_done | output | 1 | Burst of ten pulses completed |

## Verification
The bench walks every preset, at a reduced time scale, over whole periods and checks all outputs against a position model. That catches a window placed at the start of the period or one position off, which would shift every edge. Swap tests are checked at the window edges, where a missing break-before-make gap shows both rails on. The bench also drops ticks in the middle of a run to catch a counter that runs off the clock. In a ten-pulse burst, a stop off by one period, or a restart while the enable is still held, shows as a wrong idle sample or a wrong done flag.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    typedef enum logic [1:0] {
        K_CUT   = 2'd0,
        K_SWAP  = 2'd1,
        K_SPIKE = 2'd2
    } kind_t;

    localparam int CNT_W = 23;

    function automatic logic sel_ok(input logic [2:0] s);
        return (s >= 3'd1) && (s <= 3'd5);
    endfunction

    function automatic int base_period(input logic [2:0] s);
        case (s)
            3'd1:    return 100000;
            3'd2:    return 200000;
            3'd3:    return 5000000;
            3'd4:    return 20000;
            3'd5:    return 10000;
            default: return 100000;
        endcase
    endfunction

    function automatic int base_width(input logic [2:0] s);
        case (s)
            3'd1:    return 10000;
            3'd2:    return 20000;
            3'd3:    return 500000;
            3'd4:    return 1800;
            3'd5:    return 280;
            default: return 10000;
        endcase
    endfunction

    function automatic kind_t base_kind(input logic [2:0] s);
        case (s)
            3'd2, 3'd3: return K_SWAP;
            3'd5:       return K_SPIKE;
            default:    return K_CUT;
        endcase
    endfunction

endpackage

// File: rtl/sdg_preset.sv
module sdg_preset
    import sdg_pkg::*;
#(
    parameter int TIME_DIV = 1
) (
    input  logic [2:0]       sel,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] width,
    output kind_t            kind
);
    always_comb begin
        period = CNT_W'(base_period(sel) / TIME_DIV);
        width  = CNT_W'(base_width(sel) / TIME_DIV);
        kind   = base_kind(sel);
    end
endmodule

// File: rtl/sdg_drive.sv
module sdg_drive
    import sdg_pkg::*;
(
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  kind_t            kind,
    output logic             rail_a_en,
    output logic             rail_b_en,
    output logic             pulse_on
);
    logic [CNT_W-1:0] win_start;
    logic             active;
    logic             edge_pos;

    always_comb begin
        win_start = period - width;
        active    = run && (cnt >= win_start);
        edge_pos  = (cnt == win_start) || (cnt == period - 1'b1);
        pulse_on  = active;
        rail_a_en = 1'b1;
        rail_b_en = 1'b0;
        case (kind)
            K_CUT:   rail_a_en = !active;
            K_SWAP: begin
                rail_a_en = !active;
                rail_b_en = active && !edge_pos;
            end
            K_SPIKE: rail_b_en = active;
            default: ;
        endcase
    end
endmodule

// File: rtl/supply_dip_gen.sv
module supply_dip_gen
    import sdg_pkg::*;
#(
    parameter int TIME_DIV  = 1,
    parameter int BURST_LEN = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       enable,
    input  logic [2:0] test_sel,
    input  logic       burst_en,
    output logic       rail_a_en,
    output logic       rail_b_en,
    output logic       pulse_on,
    output logic       burst_done
);
    localparam int PC_W = $clog2(BURST_LEN + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic             burst;
        logic [2:0]       sel;
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  npulse;
    } state_t;

    state_t           st_d, st_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] width;
    kind_t            kind;

    sdg_preset #(.TIME_DIV(TIME_DIV)) u_preset (
        .sel    (st_q.sel),
        .period (period),
        .width  (width),
        .kind   (kind)
    );

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.run    = 1'b0;
            st_d.done   = 1'b0;
            st_d.cnt    = '0;
            st_d.npulse = '0;
        end else if (!st_q.run && !st_q.done) begin
            if (sel_ok(test_sel)) begin
                st_d.run    = 1'b1;
                st_d.sel    = test_sel;
                st_d.burst  = burst_en;
                st_d.cnt    = '0;
                st_d.npulse = '0;
            end
        end else if (st_q.run && tick_us) begin
            if (st_q.cnt == period - 1'b1) begin
                st_d.cnt = '0;
                if (st_q.burst) begin
                    if (st_q.npulse == PC_W'(BURST_LEN - 1)) begin
                        st_d.run    = 1'b0;
                        st_d.done   = 1'b1;
                        st_d.npulse = '0;
                    end else begin
                        st_d.npulse = st_q.npulse + 1'b1;
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sel <= 3'd1;
        end else begin
            st_q <= st_d;
        end
    end

    sdg_drive u_drive (
        .run       (st_q.run),
        .cnt       (st_q.cnt),
        .period    (period),
        .width     (width),
        .kind      (kind),
        .rail_a_en (rail_a_en),
        .rail_b_en (rail_b_en),
        .pulse_on  (pulse_on)
    );

    assign burst_done = st_q.done;

endmodule

// File: rtl/sdg_chk.sv
module sdg_chk
    import sdg_pkg::*;
#(
    parameter int BURST_LEN = 10,
    parameter int PC_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_us,
    input logic             enable,
    input logic [2:0]       test_sel,
    input logic             rail_a_en,
    input logic             rail_b_en,
    input logic             pulse_on,
    input logic             burst_done,
    input logic             run,
    input logic [1:0]       kind,
    input logic [CNT_W-1:0] cnt,
    input logic [PC_W-1:0]  npulse
);
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (rail_a_en && !rail_b_en && !pulse_on));

    a_r2_bad_sel_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && enable && !sel_ok(test_sel)) |=> !run);

    a_r9_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_a_en && rail_b_en) |-> (kind == 2'(K_SPIKE)));

    a_r9_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kind == 2'(K_SWAP) && $rose(rail_b_en)) |-> $past(!rail_a_en));

    a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!run && !burst_done));

    a_r11_done_not_running: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !run);

    a_r11_pulse_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        npulse < PC_W'(BURST_LEN));

    a_r13_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && enable && !tick_us) |=> $stable(cnt));
endmodule

bind supply_dip_gen sdg_chk #(.BURST_LEN(BURST_LEN), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us    (tick_us),
    .enable     (enable),
    .test_sel   (test_sel),
    .rail_a_en  (rail_a_en),
    .rail_b_en  (rail_b_en),
    .pulse_on   (pulse_on),
    .burst_done (burst_done),
    .run        (st_q.run),
    .kind       (kind),
    .cnt        (st_q.cnt),
    .npulse     (st_q.npulse)
);

// File: tb/sim_supply_dip_gen.sv
module sim_supply_dip_gen;
    localparam int DIV = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       enable = 1'b0;
    logic [2:0] test_sel = 3'd1;
    logic       burst_en = 1'b0;
    logic       rail_a_en, rail_b_en, pulse_on, burst_done;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    supply_dip_gen #(.TIME_DIV(DIV), .BURST_LEN(10)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .enable(enable),
        .test_sel(test_sel), .burst_en(burst_en), .rail_a_en(rail_a_en),
        .rail_b_en(rail_b_en), .pulse_on(pulse_on), .burst_done(burst_done)
    );

    function automatic int per_of(int t);
        case (t)
            1: return 100000 / DIV;  2: return 200000 / DIV;
            3: return 5000000 / DIV; 4: return 20000 / DIV;
            default: return 10000 / DIV;
        endcase
    endfunction

    function automatic int wid_of(int t);
        case (t)
            1: return 10000 / DIV;  2: return 20000 / DIV;
            3: return 500000 / DIV; 4: return 1800 / DIV;
            default: return 280 / DIV;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got a/b/pulse/done=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] expect_run(int t, int c);
        int  p = per_of(t);
        int  w = wid_of(t);
        logic act = (c >= p - w);
        logic a, b;
        a = 1'b1; b = 1'b0;
        if (t == 1 || t == 4) a = !act;
        else if (t == 2 || t == 3) begin
            a = !act;
            b = act && (c != p - w) && (c != p - 1);
        end else b = act;
        return {a, b, act, 1'b0};
    endfunction

    task automatic run_case(input int t, input string req, input int nsamp,
                            input bit burst, input bit gaps, input bit swap_sel);
        int  cnt = 0;
        int  pulses = 0;
        bit  stopped = 1'b0;
        int  p = per_of(t);
        @(negedge clk);
        enable = 1'b1; test_sel = 3'(t); burst_en = burst; tick_us = 1'b1;
        @(posedge clk);
        for (int i = 0; i < nsamp; i++) begin
            @(negedge clk);
            if (stopped)
                check("R11", {rail_a_en, rail_b_en, pulse_on, burst_done}, 4'b1001);
            else
                check(req, {rail_a_en, rail_b_en, pulse_on, burst_done}, expect_run(t, cnt));
            tick_us = gaps ? ((i % 5) != 2) : 1'b1;
            if (swap_sel && i == nsamp / 2) begin
                test_sel = (t == 4) ? 3'd1 : 3'd4;
                burst_en = !burst;
            end
            @(posedge clk);
            if (!stopped && tick_us) begin
                if (cnt == p - 1) begin
                    cnt = 0; pulses++;
                    if (burst && pulses == 10) stopped = 1'b1;
                end else cnt++;
            end
        end
        @(negedge clk);
        enable = 1'b0; tick_us = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10", {rail_a_en, rail_b_en, pulse_on, burst_done}, 4'b1000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {rail_a_en, rail_b_en, pulse_on, burst_done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {rail_a_en, rail_b_en, pulse_on, burst_done}, 4'b1000);

        // R2: invalid numbers never start a run
        for (int s = 0; s < 8; s++) begin
            if (s >= 1 && s <= 5) continue;
            test_sel = 3'(s); enable = 1'b1;
            repeat (20) begin
                @(negedge clk);
                check("R2", {rail_a_en, rail_b_en, pulse_on, burst_done}, 4'b1000);
            end
            enable = 1'b0;
            @(negedge clk);
        end

        // R3/R4..R8/R9: full periods of each preset
        run_case(1, "R4", 2 * per_of(1) + 3, 1'b0, 1'b0, 1'b0);
        run_case(2, "R5", 2 * per_of(2) + 3, 1'b0, 1'b0, 1'b0);
        run_case(3, "R6", per_of(3) + 5, 1'b0, 1'b0, 1'b0);
        run_case(4, "R7", 3 * per_of(4) + 3, 1'b0, 1'b0, 1'b0);
        run_case(5, "R8", 3 * per_of(5) + 3, 1'b0, 1'b0, 1'b0);
        // R13: dropped ticks, R9 swap edges with gaps
        run_case(2, "R13", 3 * per_of(2), 1'b0, 1'b1, 1'b0);
        // R12: selection changes mid-run are ignored
        run_case(5, "R12", 3 * per_of(5), 1'b0, 1'b0, 1'b1);
        // R11: ten-pulse burst, then held done with enable high
        run_case(4, "R11", 10 * per_of(4) + 30, 1'b1, 1'b0, 1'b0);
        run_case(2, "R11", 10 * per_of(2) + 10, 1'b1, 1'b1, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule